// File: doc/BRIEF.md
# Pipelined Load/Store Execution Unit

This block is the memory execution unit of a processor core. It sits between a 32-bit register file and a 32-bit on-chip memory bus. Each command carries two register operand values, a 16-bit immediate, a size, a destination register index and store data. The unit adds a base value (the first operand, or zero) to an offset (the second operand, or the sign-extended immediate). It then drives one bus transfer, or two transfers for a double-word. Load data is aligned and extended, then presented on a write-back port with a fixed latency.

The memory answers one clock after a request. A word access therefore returns its result two clocks after the command is taken, and a double-word returns its second half one clock later. The unit takes a new command every cycle. The only exception is the single cycle in which the second beat of a double-word is on the bus. A per-register pending-load scoreboard tells the issue stage to stall any command that reads or overwrites a register with a load still in flight.

Size encoding on `cmd_size`: 0 byte, 1 half-word, 2 word, 3 double-word. Byte lanes are big-endian: byte offset 0 is bits 31:24 of a bus word.

Top module: `lsu_pipe`

## Requirements
- R1: After reset `cmd_ready` is 1 and `bus_req`, `wb_valid` and `dep_stall` are 0.
- R2: The effective address is (`cmd_zero_base` ? 0 : `cmd_rs1_val`) plus (`cmd_use_imm` ? sign-extended `cmd_imm` : `cmd_rs2_val`). `bus_addr` carries this address with its two low bits cleared.
- R3: A command accepted at clock edge E drives `bus_req` in the cycle after E. For a load, it presents `wb_valid`, `wb_rd` and `wb_data` in the cycle after E+1, which is two clocks of latency.
- R4: A double-word access (size 3) uses two beats in consecutive cycles, at the address and at the address plus 4. `cmd_ready` is 0 during the first beat. A load writes the first word to `wb_rd` = rd and the second word to rd+1 (wrapping), one cycle apart, so the second word has three clocks of latency.
- R5: Outside the double-word hold cycle, commands accepted on consecutive cycles produce bus requests and write-backs on consecutive cycles, in order.
- R6: A byte load (size 0) selects lane 3-offset. The lane for offset 0 is bits 31:24. The byte is zero-filled to 32 bits, and `cmd_signed` has no effect.
- R7: A half-word load (size 1) takes bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. The value is zero-filled, or sign-extended when `cmd_signed` is 1.
- R8: A byte store drives `bus_be` = 4'b1000 >> offset with the byte repeated on all lanes. A half-word store drives 4'b1100 or 4'b0011 with the half repeated. A word store drives 4'b1111. A store never raises `wb_valid`.
- R9: A double-word store sends `cmd_st_data` on the first beat and `cmd_st_data_hi` on the second, both with `bus_be` = 4'b1111.
- R10: `dep_stall` is 1 while any of `chk_src_a`, `chk_src_b` or `chk_dst` names a register that has a load accepted but not yet written back. The bit is set on the cycle after acceptance and cleared on the cycle after its write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_store | input | 1 | 1 store, 0 load |
| cmd_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| cmd_signed | input | 1 | Sign-extend half-word loads |
| cmd_zero_base | input | 1 | Use zero instead of first operand |
| cmd_use_imm | input | 1 | Use immediate instead of second operand |
| cmd_imm | input | 16 | Immediate offset |
| cmd_rs1_val | input | 32 | First operand value |
| cmd_rs2_val | input | 32 | Second operand value |
| cmd_st_data | input | 32 | Store data (first word) |
| cmd_st_data_hi | input | 32 | Store data, second word of a double |
| cmd_rd | input | RW | Destination register of a load |
| chk_src_a | input | RW | Register read by the next command |
| chk_src_b | input | RW | Second register read by the next command |
| chk_dst | input | RW | Register written by the next command |
| dep_stall | output | 1 | Next command must wait |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Write transfer |
| bus_addr | output | 32 | Word-aligned address |
| bus_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, one cycle after request |
| wb_valid | output | 1 | Write-back valid |
| wb_rd | output | RW | Write-back register index |
| wb_data | output | 32 | Formatted load result |

## Verification
An error in the address stage shows one cycle after acceptance: a wrong `bus_addr`, `bus_be` or `bus_wdata`, or a second double-word beat that never appears. A wrong size, offset or sign flag carried into the return stage shows one cycle later as a wrong `wb_data`, or as a write-back that is missing or extra. A scoreboard bit that sticks or is lost shows through `dep_stall` as soon as the bench points a check index at that register. The bench probes such bits during flight and again just after write-back.

// File: rtl/lsu_pipe.sv
module lsu_pipe #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_store,
  input  logic [1:0]    cmd_size,
  input  logic          cmd_signed,
  input  logic          cmd_zero_base,
  input  logic          cmd_use_imm,
  input  logic [15:0]   cmd_imm,
  input  logic [31:0]   cmd_rs1_val,
  input  logic [31:0]   cmd_rs2_val,
  input  logic [31:0]   cmd_st_data,
  input  logic [31:0]   cmd_st_data_hi,
  input  logic [RW-1:0] cmd_rd,
  input  logic [RW-1:0] chk_src_a,
  input  logic [RW-1:0] chk_src_b,
  input  logic [RW-1:0] chk_dst,
  output logic          dep_stall,
  output logic          bus_req,
  output logic          bus_we,
  output logic [31:0]   bus_addr,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          wb_valid,
  output logic [RW-1:0] wb_rd,
  output logic [31:0]   wb_data
);

  logic          a_valid, a_store, a_signed, a_second;
  logic [1:0]    a_size;
  logic [31:0]   a_addr, a_wdata, a_wdata_hi;
  logic [RW-1:0] a_rd;

  logic          b_valid, b_signed;
  logic [1:0]    b_size, b_off;
  logic [RW-1:0] b_rd;

  logic [NREG-1:0] sb, sb_set, sb_clr;

  wire        a_dword = (a_size == 2'd3);
  wire        hold    = a_valid && a_dword && !a_second;
  wire        accept  = cmd_valid && cmd_ready;
  wire [31:0] base    = cmd_zero_base ? 32'd0 : cmd_rs1_val;
  wire [31:0] offs    = cmd_use_imm ? {{16{cmd_imm[15]}}, cmd_imm} : cmd_rs2_val;
  wire [1:0]  off     = a_addr[1:0];

  assign cmd_ready = !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid  <= 1'b0;
      a_second <= 1'b0;
    end else if (hold) begin
      a_second <= 1'b1;
    end else begin
      a_valid  <= accept;
      a_second <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      a_addr  <= a_addr + 32'd4;
      a_rd    <= a_rd + 1'b1;
      a_wdata <= a_wdata_hi;
    end else if (accept) begin
      a_store    <= cmd_store;
      a_size     <= cmd_size;
      a_signed   <= cmd_signed;
      a_addr     <= base + offs;
      a_rd       <= cmd_rd;
      a_wdata    <= cmd_st_data;
      a_wdata_hi <= cmd_st_data_hi;
    end
  end

  assign bus_req  = a_valid;
  assign bus_we   = a_store;
  assign bus_addr = {a_addr[31:2], 2'b00};

  always_comb begin
    case (a_size)
      2'd0:    begin bus_be = 4'b1000 >> off;                  bus_wdata = {4{a_wdata[7:0]}};  end
      2'd1:    begin bus_be = off[1] ? 4'b0011 : 4'b1100;      bus_wdata = {2{a_wdata[15:0]}}; end
      default: begin bus_be = 4'b1111;                         bus_wdata = a_wdata;            end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) b_valid <= 1'b0;
    else        b_valid <= a_valid && !a_store;
    b_size   <= a_size;
    b_signed <= a_signed;
    b_off    <= off;
    b_rd     <= a_rd;
  end

  wire [31:0] lane_sh = bus_rdata << {b_off, 3'b000};
  wire [15:0] half    = b_off[1] ? bus_rdata[15:0] : bus_rdata[31:16];

  assign wb_valid = b_valid;
  assign wb_rd    = b_rd;

  always_comb begin
    case (b_size)
      2'd0:    wb_data = {24'd0, lane_sh[31:24]};
      2'd1:    wb_data = {{16{b_signed & half[15]}}, half};
      default: wb_data = bus_rdata;
    endcase
  end

  always_comb begin
    sb_set = '0;
    sb_clr = '0;
    if (accept && !cmd_store) begin
      sb_set[cmd_rd] = 1'b1;
      if (cmd_size == 2'd3) sb_set[cmd_rd + 1'b1] = 1'b1;
    end
    if (b_valid) sb_clr[b_rd] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sb <= '0;
    else        sb <= (sb & ~sb_clr) | sb_set;
  end

  assign dep_stall = sb[chk_src_a] | sb[chk_src_b] | sb[chk_dst];

  a_r4_beat_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && a_dword && !a_second) |=> (bus_req && bus_addr == $past(bus_addr) + 32'd4));
  a_r4_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);
  a_r3_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> wb_valid);
  a_r8_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> !wb_valid);
  a_r8_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && a_size == 2'd0) |-> $countones(bus_be) == 1);
  a_r10_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_store) |=> sb[$past(cmd_rd)]);

endmodule

// File: tb/sim_lsu_pipe.sv
module sim_lsu_pipe;
  localparam int RW = 5;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_store = 0, cmd_signed = 0, cmd_zero_base = 0, cmd_use_imm = 0;
  logic [1:0] cmd_size = 0;
  logic [15:0] cmd_imm = 0;
  logic [31:0] cmd_rs1_val = 0, cmd_rs2_val = 0, cmd_st_data = 0, cmd_st_data_hi = 0;
  logic [RW-1:0] cmd_rd = 0, chk_src_a = 0, chk_src_b = 0, chk_dst = 0;
  logic cmd_ready, dep_stall, bus_req, bus_we, wb_valid;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, wb_data;
  logic [3:0] bus_be;
  logic [RW-1:0] wb_rd;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:63];

  always #5 clk = ~clk;

  lsu_pipe #(.NREG(32)) u0 (.*);

  always @(posedge clk) begin
    if (bus_req && bus_we)
      for (int k = 0; k < 4; k++)
        if (bus_be[k]) mem[bus_addr[7:2]][8*k +: 8] <= bus_wdata[8*k +: 8];
    bus_rdata <= mem[bus_addr[7:2]];
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic set_cmd(logic st, logic [1:0] sz, logic sg, logic zb, logic ui,
                         logic [15:0] imm, logic [31:0] r1, logic [31:0] r2,
                         logic [31:0] d, logic [31:0] dh, logic [RW-1:0] rd);
    cmd_valid = 1; cmd_store = st; cmd_size = sz; cmd_signed = sg; cmd_zero_base = zb;
    cmd_use_imm = ui; cmd_imm = imm; cmd_rs1_val = r1; cmd_rs2_val = r2;
    cmd_st_data = d; cmd_st_data_hi = dh; cmd_rd = rd;
  endtask

  task automatic t_load(string tag, logic [1:0] sz, logic sg, logic zb, logic ui, logic [15:0] imm,
                        logic [31:0] r1, logic [31:0] r2, logic [RW-1:0] rd,
                        logic [31:0] exp_addr, logic [31:0] exp_data);
    @(negedge clk); set_cmd(0, sz, sg, zb, ui, imm, r1, r2, 0, 0, rd);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    check({tag, " bus_req"}, {31'd0, bus_req}, 1);
    check({tag, " bus_addr"}, bus_addr, exp_addr);
    @(posedge clk);
    @(negedge clk);
    check({tag, " wb_valid"}, {31'd0, wb_valid}, 1);
    check({tag, " wb_rd"}, {27'd0, wb_rd}, {27'd0, rd});
    check({tag, " wb_data"}, wb_data, exp_data);
  endtask

  task automatic t_store(string tag, logic [1:0] sz, logic [31:0] r1, logic [15:0] imm,
                         logic [31:0] d, logic [3:0] exp_be, logic [31:0] exp_wd);
    @(negedge clk); set_cmd(1, sz, 0, 0, 1, imm, r1, 0, d, 0, 0);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    check({tag, " bus_we"}, {31'd0, bus_we}, 1);
    check({tag, " bus_be"}, {28'd0, bus_be}, {28'd0, exp_be});
    check({tag, " bus_wdata"}, bus_wdata, exp_wd);
    @(posedge clk);
    @(negedge clk);
    check({tag, " no wb"}, {31'd0, wb_valid}, 0);
  endtask

  task automatic t_dword_load;
    @(negedge clk); set_cmd(0, 3, 0, 0, 1, 16'h0040, 0, 0, 0, 0, 7);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    check("R4 beat0 addr", bus_addr, 32'h40);
    check("R4 ready low", {31'd0, cmd_ready}, 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 beat1 addr", bus_addr, 32'h44);
    check("R4 ready back", {31'd0, cmd_ready}, 1);
    check("R4 wb0 valid", {31'd0, wb_valid}, 1);
    check("R4 wb0 rd", {27'd0, wb_rd}, 7);
    check("R4 wb0 data", wb_data, 32'hCAFEBABE);
    @(posedge clk);
    @(negedge clk);
    check("R4 wb1 valid", {31'd0, wb_valid}, 1);
    check("R4 wb1 rd", {27'd0, wb_rd}, 8);
    check("R4 wb1 data", wb_data, 32'h8BADBEEF);
  endtask

  task automatic t_dword_store;
    @(negedge clk); set_cmd(1, 3, 0, 0, 1, 16'h0058, 0, 0, 32'h11112222, 32'h33334444, 0);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    check("R9 beat0 wdata", bus_wdata, 32'h11112222);
    check("R9 beat0 be", {28'd0, bus_be}, 32'hF);
    @(posedge clk);
    @(negedge clk);
    check("R9 beat1 addr", bus_addr, 32'h5C);
    check("R9 beat1 wdata", bus_wdata, 32'h33334444);
    check("R9 beat1 be", {28'd0, bus_be}, 32'hF);
    @(posedge clk);
    @(negedge clk);
    check("R9 no wb", {31'd0, wb_valid}, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); set_cmd(0, 2, 0, 0, 1, 16'h0014, 0, 0, 0, 0, 2);
    @(posedge clk);
    @(negedge clk); set_cmd(0, 2, 0, 0, 1, 16'h0020, 0, 0, 0, 0, 3);
    check("R5 ready 1", {31'd0, cmd_ready}, 1);
    @(posedge clk);
    @(negedge clk); set_cmd(0, 2, 0, 0, 1, 16'h0030, 0, 0, 0, 0, 4);
    check("R5 wb a rd", {27'd0, wb_rd}, 2);
    check("R5 wb a data", wb_data, 32'h11223344);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    check("R5 wb b rd", {27'd0, wb_rd}, 3);
    check("R5 wb b data", wb_data, 32'hA1B2C3D4);
    @(posedge clk);
    @(negedge clk);
    check("R5 wb c valid", {31'd0, wb_valid}, 1);
    check("R5 wb c data", wb_data, 32'h0BADF00D);
  endtask

  task automatic t_scoreboard;
    @(negedge clk); set_cmd(0, 2, 0, 0, 1, 16'h0014, 0, 0, 0, 0, 6);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0; chk_src_a = 6;
    #1 check("R10 stall src_a", {31'd0, dep_stall}, 1);
    chk_src_a = 9;
    #1 check("R10 other reg", {31'd0, dep_stall}, 0);
    chk_dst = 6;
    @(posedge clk);
    @(negedge clk);
    check("R10 stall at wb", {31'd0, dep_stall}, 1);
    @(posedge clk);
    @(negedge clk);
    check("R10 cleared", {31'd0, dep_stall}, 0);
    chk_dst = 0; chk_src_a = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[5] = 32'h11223344;  mem[8] = 32'hA1B2C3D4;  mem[10] = 32'h5555AAAA;
    mem[12] = 32'h0BADF00D; mem[15] = 32'h7E57C0DE; mem[16] = 32'hCAFEBABE;
    mem[17] = 32'h8BADBEEF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 ready", {31'd0, cmd_ready}, 1);
    check("R1 bus_req", {31'd0, bus_req}, 0);
    check("R1 wb_valid", {31'd0, wb_valid}, 0);
    check("R1 dep_stall", {31'd0, dep_stall}, 0);

    t_load("R3 word", 2, 0, 0, 1, 16'h0004, 32'h10, 0, 1, 32'h14, 32'h11223344);
    t_load("R2 zero base", 2, 0, 1, 1, 16'h0030, 32'hDEAD0000, 0, 1, 32'h30, 32'h0BADF00D);
    t_load("R2 neg imm", 2, 0, 0, 1, 16'hFFFC, 32'h40, 0, 1, 32'h3C, 32'h7E57C0DE);
    t_load("R2 reg offset", 2, 0, 0, 0, 16'h0000, 32'h20, 32'h8, 1, 32'h28, 32'h5555AAAA);
    t_load("R6 byte off1", 0, 1, 0, 1, 16'h0021, 0, 0, 1, 32'h20, 32'h000000B2);
    t_load("R6 byte off3", 0, 0, 0, 1, 16'h0023, 0, 0, 1, 32'h20, 32'h000000D4);
    t_load("R6 byte off0", 0, 1, 0, 1, 16'h0020, 0, 0, 1, 32'h20, 32'h000000A1);
    t_load("R7 half low sx", 1, 1, 0, 1, 16'h0022, 0, 0, 1, 32'h20, 32'hFFFFC3D4);
    t_load("R7 half low zf", 1, 0, 0, 1, 16'h0022, 0, 0, 1, 32'h20, 32'h0000C3D4);
    t_load("R7 half high sx", 1, 1, 0, 1, 16'h0020, 0, 0, 1, 32'h20, 32'hFFFFA1B2);
    t_load("R7 half positive", 1, 1, 0, 1, 16'h0028, 0, 0, 1, 32'h28, 32'h00005555);
    t_dword_load;
    t_store("R8 byte", 0, 32'h50, 16'h0001, 32'h1234565A, 4'b0100, 32'h5A5A5A5A);
    t_store("R8 half", 1, 32'h50, 16'h0002, 32'h0000BEEF, 4'b0011, 32'hBEEFBEEF);
    t_load("R8 readback", 2, 0, 0, 1, 16'h0050, 0, 0, 1, 32'h50, 32'h005ABEEF);
    t_dword_store;
    t_load("R9 readback lo", 2, 0, 0, 1, 16'h0058, 0, 0, 1, 32'h58, 32'h11112222);
    t_load("R9 readback hi", 2, 0, 0, 1, 16'h005C, 0, 0, 1, 32'h5C, 32'h33334444);
    t_back_to_back;
    t_scoreboard;
    repeat (2) @(posedge clk);
    finish_sim;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim;
  end
endmodule